// File: doc/BRIEF.md
# Issue Interlock Scoreboard

This block sits at the issue stage of an in-order integer and SIMD pipeline. Each cycle it looks at one decoded instruction descriptor and decides whether the instruction may issue in that cycle. The descriptor carries a destination register, up to three source registers with per-source use flags, a selector naming the source that feeds the shifter, and three class flags: saturating arithmetic, shift by an immediate amount, and shift by a register-held amount. An instruction with no class flag set is a plain ALU operation. When the instruction cannot issue, the block reports how many more cycles it will wait.

Readiness is tracked by a table with one countdown per architectural register. When an instruction issues, its destination entry is loaded with the producer's result latency. A consumer's wait depends on that countdown and also on how the consumer uses the operand: an operand routed through the shifter by an immediate amount needs one more cycle. A register-amount shift also starts an issue-penalty countdown that blocks the next instructions whether or not they depend on it. A stalled descriptor is held by the upstream stage through the valid/ready handshake, and it writes nothing into the table until it issues.

Top module: `issue_interlock`

## Requirements
- R1: After a synchronous reset every readiness countdown and the issue-penalty countdown are zero. `in_ready` is high and the first instruction issues in the cycle it is presented.
- R2: A plain ALU result has a latency of one cycle. A dependent instruction presented in the very next cycle issues with no stall.
- R3: A saturating result has a latency of two cycles. A dependent instruction presented right after it stalls exactly one cycle, and a following instruction that does not read the saturating destination does not stall.
- R4: A source selected by `shift_sel` while `cls_imm_shift` is high needs one cycle more than its countdown. Reading the previous instruction's plain result this way stalls one cycle, and with one independent instruction in between it stalls zero cycles.
- R5: A register-amount shift instruction (`cls_reg_shift`) blocks issue for the next two cycles even for independent instructions, and `stall_cycles` reads 2 in the first blocked cycle.
- R6: A register-amount shift adds two cycles to its result latency (three for a plain one, four if also saturating). A shift-by-immediate consumer presented right after it stalls three cycles, and a plain dependent of a saturating register-shift producer stalls three cycles.
- R7: While a valid descriptor is held unchanged and stalled, `stall_cycles` drops by exactly one per cycle. The held descriptor writes no table entry before it issues.
- R8: An instruction may name its own destination as a source. The hazard check uses the countdown as it was before the instruction issued, and the new latency then applies to later readers.
- R9: `stall_cycles` is the larger of the issue-penalty countdown and, over all sources whose `src_use` bit is 1, the source countdown plus its shifter extra minus one, floored at zero. Sources with `src_use` 0 are ignored.
- R10: An instruction with `dst_en` 0 leaves the table unchanged, so a later reader of that register index does not stall on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Descriptor present this cycle |
| in_ready | output | 1 | Descriptor may issue this cycle (stall count zero) |
| dst_idx | input | IDX_W (4) | Destination register index |
| dst_en | input | 1 | Instruction writes its destination |
| src_idx | input | NUM_SRC*IDX_W (12) | Source indices, source 0 in the lowest IDX_W bits |
| src_use | input | NUM_SRC (3) | Bit s high means source s is read |
| shift_sel | input | SEL_W (2) | Source index that feeds the shifter |
| cls_sat | input | 1 | Saturating arithmetic |
| cls_imm_shift | input | 1 | Shifter operand shifted by an immediate amount |
| cls_reg_shift | input | 1 | Shifter operand shifted by a register-held amount |
| issue | output | 1 | Instruction issues this cycle (in_valid and in_ready) |
| stall | output | 1 | Valid instruction held this cycle |
| stall_cycles | output | ST_W (3) | Cycles left before the presented instruction can issue |

## Verification
The bench sends back-to-back sequences where a one-cycle error in latency shows up as an issue count that is off by one. A saturating producer given plain latency would let its dependent through without the required bubble. A shift-by-immediate consumer that ignores the extra cycle would issue early, and one that adds the extra cycle to the wrong source would stall an independent read. A register-amount shift whose issue penalty is checked only against dependents would let an unrelated instruction slip through. A missing result penalty shows up only when a shift consumer or a saturating register-shift producer is involved, so those pairs are tested directly. Self-dependent instructions, masked sources and writes with `dst_en` low catch designs that read the new latency, check unused sources, or write the table when they should not.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  // Result latency of a producer, from its class flags.
  function automatic int unsigned result_latency(
    input logic        sat,
    input logic        reg_shift,
    input int unsigned base_lat,
    input int unsigned sat_extra,
    input int unsigned rsh_extra
  );
    int unsigned lat;
    lat = base_lat;
    if (sat)       lat = lat + sat_extra;
    if (reg_shift) lat = lat + rsh_extra;
    return lat;
  endfunction

  // Cycles a consumer needs on one operand, counting the shifter extra.
  function automatic int unsigned operand_need(
    input int unsigned cnt,
    input logic        via_imm_shifter,
    input int unsigned imm_extra
  );
    return via_imm_shifter ? cnt + imm_extra : cnt;
  endfunction

  // A need of n cycles means n-1 stall cycles, floored at zero.
  function automatic int unsigned need_to_stall(input int unsigned need);
    return (need > 0) ? need - 1 : 0;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ilk_ready_table.sv
module ilk_ready_table #(
  parameter int NUM_REGS = 16,
  parameter int NUM_SRC  = 3,
  parameter int IDX_W    = 4,
  parameter int CNT_W    = 3
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [CNT_W-1:0]                 wr_val,
  input  logic [NUM_SRC-1:0][IDX_W-1:0]    rd_idx,
  output logic [NUM_SRC-1:0][CNT_W-1:0]    rd_cnt
);

  logic [CNT_W-1:0] cnt_q [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(r));

    always_ff @(posedge clk) begin
      if (rst)
        cnt_q[r] <= '0;
      else if (hit)
        cnt_q[r] <= wr_val;
      else if (cnt_q[r] != '0)
        cnt_q[r] <= cnt_q[r] - CNT_W'(1);
    end

    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (rst)
      hit |=> cnt_q[r] == $past(wr_val)); // R2
    AST_CNT_DECAY: assert property (@(posedge clk) disable iff (rst)
      (!hit && cnt_q[r] != '0) |=> cnt_q[r] == $past(cnt_q[r]) - CNT_W'(1)); // R7
    AST_CNT_HOLD_ZERO: assert property (@(posedge clk) disable iff (rst)
      (!hit && cnt_q[r] == '0) |=> cnt_q[r] == '0); // R10
  end

  // Reads return the value held before any write in this cycle.
  always_comb begin
    for (int s = 0; s < NUM_SRC; s++)
      rd_cnt[s] = cnt_q[rd_idx[s]];
  end

endmodule

// File: rtl/ilk_penalty_ctr.sv
module ilk_penalty_ctr #(
  parameter int PEN_CYC = 2,
  parameter int PEN_W   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  logic             load,
  output logic [PEN_W-1:0] pen_cnt
);

  logic [PEN_W-1:0] pen_q;

  always_ff @(posedge clk) begin
    if (rst)
      pen_q <= '0;
    else if (load)
      pen_q <= PEN_W'(PEN_CYC);
    else if (pen_q != '0)
      pen_q <= pen_q - PEN_W'(1);
  end

  assign pen_cnt = pen_q;

  AST_PEN_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> pen_q == PEN_W'(PEN_CYC)); // R5
  AST_PEN_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (pen_q != '0) |-> !issue); // R5
  AST_PEN_LOAD_ON_ISSUE: assert property (@(posedge clk) disable iff (rst)
    load |-> issue); // R5

endmodule

// File: rtl/ilk_hazard_eval.sv
module ilk_hazard_eval #(
  parameter int NUM_SRC     = 3,
  parameter int CNT_W       = 3,
  parameter int SEL_W       = 2,
  parameter int NEED_W      = 3,
  parameter int PEN_W       = 2,
  parameter int ST_W        = 3,
  parameter int IMMSH_EXTRA = 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  input  logic [NUM_SRC-1:0][CNT_W-1:0] src_cnt,
  input  logic [NUM_SRC-1:0]            src_use,
  input  logic [SEL_W-1:0]              shift_sel,
  input  logic                          imm_shift,
  input  logic [PEN_W-1:0]              pen_cnt,
  output logic [ST_W-1:0]               data_stall,
  output logic [ST_W-1:0]               stall_cnt
);

  logic [NUM_SRC-1:0][ST_W-1:0] per_src_stall;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic             shifted;
    logic [NEED_W-1:0] need;
    assign shifted = imm_shift && (shift_sel == SEL_W'(s));
    assign need = src_use[s]
      ? NEED_W'(ilk_pkg::operand_need(int'(unsigned'(src_cnt[s])), shifted, IMMSH_EXTRA))
      : '0;
    assign per_src_stall[s] = ST_W'(ilk_pkg::need_to_stall(int'(unsigned'(need))));
  end

  always_comb begin
    int unsigned acc;
    acc = 0;
    for (int s = 0; s < NUM_SRC; s++)
      acc = ilk_pkg::max_u(acc, int'(unsigned'(per_src_stall[s])));
    data_stall = ST_W'(acc);
  end

  always_comb begin
    if (in_valid)
      stall_cnt = ST_W'(ilk_pkg::max_u(int'(unsigned'(data_stall)),
                                       int'(unsigned'(pen_cnt))));
    else
      stall_cnt = ST_W'(pen_cnt);
  end

  AST_PEN_DOMINATES: assert property (@(posedge clk) disable iff (rst)
    stall_cnt >= ST_W'(pen_cnt)); // R9
  AST_UNUSED_SRC_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (src_use == '0 && pen_cnt == '0) |-> stall_cnt == '0); // R9

endmodule

// File: rtl/issue_interlock.sv
module issue_interlock #(
  parameter int NUM_REGS    = 16,
  parameter int NUM_SRC     = 3,
  parameter int ALU_LAT     = 1,
  parameter int SAT_EXTRA   = 1,
  parameter int IMMSH_EXTRA = 1,
  parameter int RSH_RESULT  = 2,
  parameter int RSH_ISSUE   = 2,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int SEL_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int MAX_LAT = ALU_LAT + SAT_EXTRA + RSH_RESULT,
  localparam int CNT_W   = $clog2(MAX_LAT + 1),
  localparam int NEED_W  = $clog2(MAX_LAT + IMMSH_EXTRA + 1),
  localparam int PEN_W   = $clog2(RSH_ISSUE + 1),
  localparam int ST_W    = (NEED_W > PEN_W) ? NEED_W : PEN_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [IDX_W-1:0]         dst_idx,
  input  logic                     dst_en,
  input  logic [NUM_SRC*IDX_W-1:0] src_idx,
  input  logic [NUM_SRC-1:0]       src_use,
  input  logic [SEL_W-1:0]         shift_sel,
  input  logic                     cls_sat,
  input  logic                     cls_imm_shift,
  input  logic                     cls_reg_shift,
  output logic                     issue,
  output logic                     stall,
  output logic [ST_W-1:0]          stall_cycles
);

  logic [NUM_SRC-1:0][IDX_W-1:0] rd_idx;
  logic [NUM_SRC-1:0][CNT_W-1:0] rd_cnt;
  logic [CNT_W-1:0]              new_lat;
  logic                          tbl_wr;
  logic                          pen_load;
  logic [PEN_W-1:0]              pen_cnt;
  logic [ST_W-1:0]               data_stall;
  logic [ST_W-1:0]               stall_cnt;

  assign rd_idx  = src_idx;
  assign new_lat = CNT_W'(ilk_pkg::result_latency(cls_sat, cls_reg_shift,
                                                  ALU_LAT, SAT_EXTRA, RSH_RESULT));

  assign in_ready     = (stall_cnt == '0);
  assign issue        = in_valid && in_ready;
  assign stall        = in_valid && !in_ready;
  assign stall_cycles = stall_cnt;
  assign tbl_wr       = issue && dst_en;
  assign pen_load     = issue && cls_reg_shift;

  ilk_ready_table #(
    .NUM_REGS (NUM_REGS),
    .NUM_SRC  (NUM_SRC),
    .IDX_W    (IDX_W),
    .CNT_W    (CNT_W)
  ) table_i (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (tbl_wr),
    .wr_idx (dst_idx),
    .wr_val (new_lat),
    .rd_idx (rd_idx),
    .rd_cnt (rd_cnt)
  );

  ilk_penalty_ctr #(
    .PEN_CYC (RSH_ISSUE),
    .PEN_W   (PEN_W)
  ) pen_i (
    .clk     (clk),
    .rst     (rst),
    .issue   (issue),
    .load    (pen_load),
    .pen_cnt (pen_cnt)
  );

  ilk_hazard_eval #(
    .NUM_SRC     (NUM_SRC),
    .CNT_W       (CNT_W),
    .SEL_W       (SEL_W),
    .NEED_W      (NEED_W),
    .PEN_W       (PEN_W),
    .ST_W        (ST_W),
    .IMMSH_EXTRA (IMMSH_EXTRA)
  ) haz_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .src_cnt    (rd_cnt),
    .src_use    (src_use),
    .shift_sel  (shift_sel),
    .imm_shift  (cls_imm_shift),
    .pen_cnt    (pen_cnt),
    .data_stall (data_stall),
    .stall_cnt  (stall_cnt)
  );

  AST_RESET_READY: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> in_ready); // R1
  AST_STALL_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && $past(in_valid && !in_ready) &&
     $stable({dst_idx, dst_en, src_idx, src_use, shift_sel,
              cls_sat, cls_imm_shift, cls_reg_shift}))
    |-> stall_cycles == $past(stall_cycles) - ST_W'(1)); // R7
  AST_HANDSHAKE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(issue && stall)); // R7
  AST_DATA_WITHIN_TOTAL: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> stall_cycles >= data_stall); // R9

endmodule

// File: tb/issue_interlock_tb_top.sv
module issue_interlock_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [3:0]  dst_idx;
  logic        dst_en;
  logic [11:0] src_idx;
  logic [2:0]  src_use;
  logic [1:0]  shift_sel;
  logic        cls_sat;
  logic        cls_imm_shift;
  logic        cls_reg_shift;
  logic        issue;
  logic        stall;
  logic [2:0]  stall_cycles;

  int n_vec  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  issue_interlock dut_i (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .dst_idx       (dst_idx),
    .dst_en        (dst_en),
    .src_idx       (src_idx),
    .src_use       (src_use),
    .shift_sel     (shift_sel),
    .cls_sat       (cls_sat),
    .cls_imm_shift (cls_imm_shift),
    .cls_reg_shift (cls_reg_shift),
    .issue         (issue),
    .stall         (stall),
    .stall_cycles  (stall_cycles)
  );

  task automatic chk(input int act, input int exp, input string what);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // Present one descriptor and hold it until it issues.
  // Returns stall count and the stall_cycles values of the first two held cycles.
  task automatic send(input int d, input bit de, input int s0, input int s1, input int s2,
                      input bit [2:0] use_m, input int sel, input bit sat, input bit imm,
                      input bit rsh, output int n_st, output int sc1, output int sc2);
    n_st = 0; sc1 = -1; sc2 = -1;
    @(negedge clk);
    dst_idx = 4'(d); dst_en = de;
    src_idx = {4'(s2), 4'(s1), 4'(s0)};
    src_use = use_m; shift_sel = 2'(sel);
    cls_sat = sat; cls_imm_shift = imm; cls_reg_shift = rsh;
    in_valid = 1'b1;
    for (int k = 0; k < 20; k++) begin
      #1;
      if (in_ready) break;
      if (n_st == 0) sc1 = int'(stall_cycles);
      if (n_st == 1) sc2 = int'(stall_cycles);
      n_st++;
      @(negedge clk);
    end
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b0;
    dst_idx = '0; dst_en = 1'b0; src_idx = '0; src_use = '0; shift_sel = '0;
    cls_sat = 1'b0; cls_imm_shift = 1'b0; cls_reg_shift = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk); #1;
    chk(int'(in_ready), 1, "R1 in_ready after reset");
    chk(int'(stall_cycles), 0, "R1 stall_cycles after reset");
    begin
      int n, a, b;
      send(1, 1, 2, 3, 0, 3'b011, 0, 0, 0, 0, n, a, b);
      chk(n, 0, "R1 first instruction stalls");
    end
  endtask

  task automatic t_plain();
    int n, a, b;
    idle(5);
    send(4, 1, 2, 1, 0, 3'b011, 0, 0, 0, 0, n, a, b);
    send(5, 1, 4, 1, 0, 3'b011, 0, 0, 0, 0, n, a, b);
    chk(n, 0, "R2 plain dependent stalls");
    send(6, 1, 5, 5, 0, 3'b011, 0, 0, 0, 0, n, a, b);
    chk(n, 0, "R2 plain chain stalls");
  endtask

  task automatic t_sat();
    int n, a, b;
    idle(5);
    send(4, 1, 2, 1, 0, 3'b011, 0, 1, 0, 0, n, a, b);
    send(5, 1, 4, 1, 0, 3'b011, 0, 1, 0, 0, n, a, b);
    chk(n, 1, "R3 saturating dependent stalls");
    chk(a, 1, "R3 stall_cycles on saturating dependent");
    idle(5);
    send(4, 1, 2, 1, 0, 3'b011, 0, 1, 0, 0, n, a, b);
    send(6, 1, 2, 1, 0, 3'b011, 0, 1, 0, 0, n, a, b);
    chk(n, 0, "R3 independent after saturating stalls");
  endtask

  task automatic t_imm_shift();
    int n, a, b;
    idle(5);
    send(1, 1, 2, 3, 0, 3'b011, 0, 0, 0, 0, n, a, b);
    send(4, 1, 1, 0, 0, 3'b001, 0, 0, 1, 0, n, a, b);
    chk(n, 1, "R4 immediate-shift consumer back to back");
    idle(5);
    send(1, 1, 2, 3, 0, 3'b011, 0, 0, 0, 0, n, a, b);
    send(6, 1, 7, 8, 0, 3'b011, 0, 0, 0, 0, n, a, b);
    send(4, 1, 1, 0, 0, 3'b001, 0, 0, 1, 0, n, a, b);
    chk(n, 0, "R4 immediate-shift consumer one apart");
  endtask

  task automatic t_reg_shift();
    int n, a, b;
    idle(5);
    send(5, 1, 6, 2, 3, 3'b111, 1, 0, 0, 1, n, a, b);
    send(7, 1, 8, 9, 0, 3'b011, 0, 0, 0, 0, n, a, b);
    chk(n, 2, "R5 independent after register shift stalls");
    chk(a, 2, "R5 first stall_cycles after register shift");
    chk(b, 1, "R7 stall_cycles counts down while held");
    idle(5);
    send(5, 1, 6, 2, 3, 3'b111, 1, 0, 0, 1, n, a, b);
    send(7, 1, 5, 8, 0, 3'b011, 0, 0, 0, 0, n, a, b);
    chk(n, 2, "R5 plain dependent after register shift stalls");
    idle(5);
    send(5, 1, 6, 2, 3, 3'b111, 1, 0, 0, 1, n, a, b);
    send(7, 1, 5, 0, 0, 3'b001, 0, 0, 1, 0, n, a, b);
    chk(n, 3, "R6 immediate-shift consumer of register shift");
    chk(a, 3, "R6 first stall_cycles of that consumer");
    chk(b, 2, "R7 second stall_cycles of that consumer");
    idle(5);
    send(5, 1, 6, 2, 3, 3'b111, 1, 1, 0, 1, n, a, b);
    send(7, 1, 5, 8, 0, 3'b011, 0, 0, 0, 0, n, a, b);
    chk(n, 3, "R6 dependent of saturating register shift");
  endtask

  task automatic t_self();
    int n, a, b;
    idle(5);
    send(7, 1, 7, 2, 0, 3'b011, 0, 1, 0, 0, n, a, b);
    chk(n, 0, "R8 self-dependent saturating issues");
    send(9, 1, 7, 0, 0, 3'b001, 0, 0, 0, 0, n, a, b);
    chk(n, 1, "R8 reader after self-dependent saturating");
  endtask

  task automatic t_no_write();
    int n, a, b;
    idle(5);
    send(3, 0, 2, 1, 0, 3'b011, 0, 1, 0, 1, n, a, b);
    idle(3);
    send(10, 1, 3, 0, 0, 3'b001, 0, 0, 1, 0, n, a, b);
    chk(n, 0, "R10 reader of unwritten destination");
  endtask

  task automatic t_mask();
    int n, a, b;
    idle(5);
    send(8, 1, 2, 1, 0, 3'b011, 0, 1, 0, 0, n, a, b);
    send(11, 1, 8, 2, 0, 3'b010, 0, 0, 0, 0, n, a, b);
    chk(n, 0, "R9 unused source ignored");
    idle(5);
    send(8, 1, 2, 1, 0, 3'b011, 0, 1, 0, 0, n, a, b);
    send(9, 1, 2, 1, 0, 3'b011, 0, 0, 0, 0, n, a, b);
    send(12, 1, 8, 9, 0, 3'b011, 1, 0, 1, 0, n, a, b);
    chk(n, 1, "R9 maximum over sources");
    chk(a, 1, "R9 stall_cycles is maximum over sources");
  endtask

  initial begin
    t_reset();
    t_plain();
    t_sat();
    t_imm_shift();
    t_reg_shift();
    t_self();
    t_no_write();
    t_mask();
    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_vec++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule